// File: doc/BRIEF.md
# Three-Slot Decode Steering Unit

This block sits after instruction-length marking. It takes a window of up to three pre-marked instructions each cycle and places them into one of three decode slots. Slot 0 is the complex slot and accepts any instruction. Slots 1 and 2 are simple slots and accept only short, single-uop instructions that carry no prefix penalty. Slots are filled strictly in program order. The first instruction that cannot go into the next simple slot ends the group, and every instruction after it waits for slot 0 in a later cycle.

Instructions that need more than four uops, carry several prefixes, or carry a prefix that changes the length of an immediate hold slot 0 for extra cycles before they issue. The block reports how many window entries it consumed in the current cycle. The feeder uses that count to shift its queue. One cycle later the block presents the registered decode group, which carries per-slot valid bits, per-slot tags and the group's total uop count. It also keeps two free-running counters: one for stall cycles and one for active decode cycles. Together they give the total decode time of a stream.

Top module: `decode_steer`

## Requirements
- R1: A synchronous active-low reset clears the group valids, the stall flag, the stall counter and the active counter, and abandons any stall in progress. The first head presented after reset that costs one cycle issues with no stall.
- R2: In every cycle with a valid head (window lane 0) and no pending stall, the head goes to slot 0. `take_cnt` reports, in that same cycle, how many lanes were consumed. On the next clock edge `grp_vld` bit k is set for each filled slot k, and `grp_tag` slice k holds the tag of lane k. Only lanes that are valid can be taken.
- R3: Lane 1 (and lane 2) goes to a simple slot only under all of the following conditions:
  - its uop count is exactly 1;
  - its length is at most 8 bytes;
  - its prefix count is below 2;
  - its length-changing-prefix flag is clear.
  Lane 2 is considered only if lane 1 was taken. Otherwise the group ends at that lane.
- R4: A lane 1 or lane 2 instruction whose window-start flag is set is never paired. The group ends before it. A head with the flag set issues normally.
- R5: A head needing more than 4 uops costs ceil(uops/4) cycles. The first ceil(uops/4)-1 of those cycles are stalls, and the head issues alone (group mask 001). A head of exactly 4 uops may pair.
- R6: A head with the length-changing-prefix flag set adds LCP_STALL stall cycles (default 3) before it issues.
- R7: A head with a prefix count of 2 or more adds one stall cycle per prefix. A prefix count of 0 or 1 costs nothing, including on lanes 1 and 2. The costs in R5, R6 and R7 add together.
- R8: In a stall cycle, `take_cnt` is 0. On the following edge, `grp_stall` is 1, `grp_vld` is 000, and `stall_cycles` increments by one.
- R9: `grp_uops` is the sum of the uop counts in the registered group. A 4-1-1 window yields 6 in a single group, while a 2-2-2 window yields 2 (slot 0 only).
- R10: `active_cycles` increments once for every stall or issue cycle. Over a stream it therefore equals the stream's total decode cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_vld | input | 3 | Lane valid bits, packed from lane 0 upward |
| win_tag | input | 3*TAG_W | Per-lane instruction tag |
| win_uops | input | 3*UOP_W | Per-lane uop count |
| win_len | input | 3*LEN_W | Per-lane byte length |
| win_pfx | input | 3*PFX_W | Per-lane prefix count |
| win_lcp | input | 3 | Per-lane flag: a prefix changes the immediate length |
| win_first | input | 3 | Per-lane flag: first instruction of a fetch window |
| take_cnt | output | 2 | Lanes consumed this cycle (0 to 3) |
| grp_vld | output | 3 | Registered slot valid bits |
| grp_tag | output | 3*TAG_W | Registered slot tags |
| grp_uops | output | UOP_W+1 | Registered total uops in the group |
| grp_stall | output | 1 | Registered flag: the previous cycle was a stall |
| stall_cycles | output | CNT_W | Count of stall cycles since reset |
| active_cycles | output | CNT_W | Count of stall-or-issue cycles since reset |

## Verification
The two functions that meet on one instruction are multi-cycle occupancy of slot 0 by a head with many uops and the prefix penalties. Both extend the same hold, and their costs must add. The bench provokes this with two heads:
- a head of 6 uops with three prefixes, which must stall 4 cycles;
- a head of 13 uops with the length-changing flag, which must stall 6 cycles.

Each of these heads sits beside simple lanes that must not ride along. The outcome is judged on three things: the number of zero-take cycles before the issue, a group mask of 001, and the exact growth of the stall and active counters.

// File: rtl/ds_pkg.sv
// Package for the decode steering unit.
// Holds the fixed slot count, the hold sequencer states and a
// ceiling-division helper. Assumes slot count stays at three.
package ds_pkg;
    localparam int DS_LANES = 3;

    typedef enum logic [1:0] {
        HS_READY = 2'd0,   // no pending hold, head may issue or start a hold
        HS_WAIT  = 2'd1,   // counting down stall cycles
        HS_ARMED = 2'd2    // hold paid, head issues on its next valid cycle
    } hold_state_e;

    function automatic int ds_ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction
endpackage

// File: rtl/ds_lane_class.sv
// Classifies one window lane.
// Computes the total slot-0 occupancy cost in cycles (uop spill, prefix
// count penalty, length-changing prefix penalty), whether the lane is
// eligible for a simple slot, and whether it needs more uops than slot 0
// produces per cycle. Purely combinational; assumes uops >= 1 on valid lanes.
module ds_lane_class #(
    parameter int UOP_W      = 4,
    parameter int LEN_W      = 4,
    parameter int PFX_W      = 3,
    parameter int CST_W      = 6,
    parameter int D0_UOPS    = 4,
    parameter int SIMPLE_LEN = 8,
    parameter int LCP_STALL  = 3
) (
    input  logic [UOP_W-1:0] uops,
    input  logic [LEN_W-1:0] len,
    input  logic [PFX_W-1:0] pfx,
    input  logic             lcp,
    output logic [CST_W-1:0] cost,
    output logic             pair_ok,
    output logic             multi
);
    import ds_pkg::*;

    logic [CST_W-1:0] spill_c;
    logic [CST_W-1:0] pfx_c;
    logic [CST_W-1:0] lcp_c;
    logic             many_pfx;

    // Cost pieces: uop spill cycles, multi-prefix cycles, length-changing cycles.
    always_comb begin
        spill_c  = CST_W'(ds_ceil_div(int'(uops), D0_UOPS));
        if (spill_c == '0) spill_c = CST_W'(1);
        many_pfx = (pfx >= PFX_W'(2));
        pfx_c    = many_pfx ? CST_W'(pfx) : '0;
        lcp_c    = lcp ? CST_W'(LCP_STALL) : '0;
    end

    // Sum of pieces is the cycles the lane would hold slot 0.
    always_comb cost = spill_c + pfx_c + lcp_c;

    // Simple-slot eligibility: one uop, short, no prefix penalty.
    always_comb pair_ok = (uops == UOP_W'(1)) && (int'(len) <= SIMPLE_LEN)
                          && !many_pfx && !lcp;

    // More uops than slot 0 emits per cycle.
    always_comb multi = (int'(uops) > D0_UOPS);
endmodule

// File: rtl/ds_hold_ctrl.sv
// Slot-0 hold sequencer.
// When the head costs more than one cycle, stalls for cost-1 cycles and
// then lets the head issue. Assumes the feeder holds the head steady
// until it is consumed. Synchronous active-low reset abandons a hold.
module ds_hold_ctrl #(
    parameter int CST_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_vld,
    input  logic [CST_W-1:0] head_cost,
    output logic             stall,
    output logic             issue
);
    import ds_pkg::*;

    hold_state_e      st_q;
    logic [CST_W-1:0] rem_q;
    logic             need_hold;

    // Head needs a hold when it costs more than one cycle and none is paid.
    always_comb need_hold = head_vld && (head_cost > CST_W'(1)) && (st_q == HS_READY);

    // Stall while counting or while starting a hold; otherwise issue a valid head.
    always_comb begin
        stall = (st_q == HS_WAIT) || need_hold;
        issue = head_vld && !stall;
    end

    // Sequencer state and remaining stall count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= HS_READY;
            rem_q <= '0;
        end else begin
            unique case (st_q)
                HS_READY: if (need_hold) begin
                    rem_q <= head_cost - CST_W'(2);
                    st_q  <= (head_cost == CST_W'(2)) ? HS_ARMED : HS_WAIT;
                end
                HS_WAIT: begin
                    rem_q <= rem_q - CST_W'(1);
                    if (rem_q == CST_W'(1)) st_q <= HS_ARMED;
                end
                HS_ARMED: if (head_vld) st_q <= HS_READY;
                default: st_q <= HS_READY;
            endcase
        end
    end

    // R8: a wait period never ends without an armed issue slot following it.
    a_r8_wait_to_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_WAIT && rem_q == CST_W'(1)) |=> (st_q == HS_ARMED));

    // R5: once armed with a valid head, the next state releases the hold.
    a_r5_armed_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_ARMED && head_vld) |=> (st_q == HS_READY));
endmodule

// File: rtl/ds_slot_pick.sv
// In-order slot assignment.
// Slot 0 takes the head on issue; slot 1 takes lane 1 if the head is not
// multi-cycle and lane 1 is simple and not a window start; slot 2 takes
// lane 2 only after slot 1 was filled. Assumes valid lanes are packed.
module ds_slot_pick (
    input  logic       issue,
    input  logic       head_multi,
    input  logic [2:1] lane_vld,
    input  logic [2:1] lane_ok,
    input  logic [2:1] lane_first,
    output logic [2:0] slot,
    output logic [1:0] take_cnt
);
    // Fill slots strictly in order; the first refusal ends the group.
    always_comb begin
        slot[0] = issue;
        slot[1] = slot[0] && !head_multi && lane_vld[1] && lane_ok[1] && !lane_first[1];
        slot[2] = slot[1] && lane_vld[2] && lane_ok[2] && !lane_first[2];
    end

    // Consumed lane count for the feeder.
    always_comb take_cnt = {1'b0, slot[0]} + {1'b0, slot[1]} + {1'b0, slot[2]};
endmodule

// File: rtl/decode_steer.sv
// Three-slot decode steering unit (top).
// Classifies each window lane, sequences slot-0 holds, assigns slots in
// order, registers the decode group and keeps stall and active cycle
// counters. Assumes win_vld is packed from lane 0 and that the feeder
// shifts its queue by take_cnt at each clock edge.
module decode_steer #(
    parameter int TAG_W      = 6,
    parameter int UOP_W      = 4,
    parameter int LEN_W      = 4,
    parameter int PFX_W      = 3,
    parameter int D0_UOPS    = 4,
    parameter int SIMPLE_LEN = 8,
    parameter int LCP_STALL  = 3,
    parameter int CNT_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            win_vld,
    input  logic [3*TAG_W-1:0]    win_tag,
    input  logic [3*UOP_W-1:0]    win_uops,
    input  logic [3*LEN_W-1:0]    win_len,
    input  logic [3*PFX_W-1:0]    win_pfx,
    input  logic [2:0]            win_lcp,
    input  logic [2:0]            win_first,
    output logic [1:0]            take_cnt,
    output logic [2:0]            grp_vld,
    output logic [3*TAG_W-1:0]    grp_tag,
    output logic [UOP_W:0]        grp_uops,
    output logic                  grp_stall,
    output logic [CNT_W-1:0]      stall_cycles,
    output logic [CNT_W-1:0]      active_cycles
);
    import ds_pkg::*;

    localparam int CST_W = $clog2(ds_ceil_div((1 << UOP_W) - 1, D0_UOPS)
                                  + (1 << PFX_W) + LCP_STALL + 1) + 1;
    localparam int SUM_W = UOP_W + 1;

    logic [CST_W-1:0] cost_v  [DS_LANES];
    logic [2:0]       pair_v;
    logic [2:0]       multi_v;
    logic             stall;
    logic             issue;
    logic [2:0]       slot;
    logic [SUM_W-1:0] uop_sum;
    logic             unused_lane_bits;

    // One classifier per window lane.
    for (genvar k = 0; k < DS_LANES; k++) begin : g_lane
        ds_lane_class #(
            .UOP_W(UOP_W), .LEN_W(LEN_W), .PFX_W(PFX_W), .CST_W(CST_W),
            .D0_UOPS(D0_UOPS), .SIMPLE_LEN(SIMPLE_LEN), .LCP_STALL(LCP_STALL)
        ) u_class (
            .uops   (win_uops[k*UOP_W +: UOP_W]),
            .len    (win_len[k*LEN_W +: LEN_W]),
            .pfx    (win_pfx[k*PFX_W +: PFX_W]),
            .lcp    (win_lcp[k]),
            .cost   (cost_v[k]),
            .pair_ok(pair_v[k]),
            .multi  (multi_v[k])
        );
    end

    // Only the head's cost and multi flag and lanes 1-2 pairing are consumed.
    assign unused_lane_bits = ^{pair_v[0], multi_v[2:1], cost_v[1], cost_v[2], win_first[0]};

    ds_hold_ctrl #(.CST_W(CST_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .head_vld (win_vld[0]),
        .head_cost(cost_v[0]),
        .stall    (stall),
        .issue    (issue)
    );

    ds_slot_pick u_pick (
        .issue     (issue),
        .head_multi(multi_v[0]),
        .lane_vld  (win_vld[2:1]),
        .lane_ok   (pair_v[2:1]),
        .lane_first(win_first[2:1]),
        .slot      (slot),
        .take_cnt  (take_cnt)
    );

    // Total uops of the slots being filled this cycle.
    always_comb begin
        uop_sum = '0;
        for (int k = 0; k < DS_LANES; k++)
            if (slot[k]) uop_sum = uop_sum + SUM_W'(win_uops[k*UOP_W +: UOP_W]);
    end

    // Decode group register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_vld   <= '0;
            grp_tag   <= '0;
            grp_uops  <= '0;
            grp_stall <= 1'b0;
        end else begin
            grp_vld   <= slot;
            grp_tag   <= win_tag;
            grp_uops  <= uop_sum;
            grp_stall <= stall;
        end
    end

    // Stall and active cycle counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_cycles  <= '0;
            active_cycles <= '0;
        end else begin
            if (stall)          stall_cycles  <= stall_cycles + CNT_W'(1);
            if (stall || issue) active_cycles <= active_cycles + CNT_W'(1);
        end
    end

    // R2: the registered group holds exactly the lanes consumed one cycle earlier.
    a_r2_group_matches_take: assert property (@(posedge clk) disable iff (!rst_n)
        (take_cnt != 2'd0) |=> ($countones(grp_vld) == 32'($past(take_cnt))));

    // R2: nothing consumed means an empty group next cycle.
    a_r2_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (take_cnt == 2'd0) |=> (grp_vld == 3'b000));

    // R2: window lanes arrive packed from lane 0.
    a_r2_window_packed: assert property (@(posedge clk) disable iff (!rst_n)
        (win_vld[2] |-> win_vld[1]) and (win_vld[1] |-> win_vld[0]));

    // R3: slots fill in order.
    a_r3_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_vld[2] |-> grp_vld[1]) and (grp_vld[1] |-> grp_vld[0]));

    // R4: a window-start instruction in lane 1 is never paired.
    a_r4_first_not_paired: assert property (@(posedge clk) disable iff (!rst_n)
        (take_cnt >= 2'd2) |-> !win_first[1]);

    // R5: a head needing more uops than slot 0 emits issues alone.
    a_r5_multi_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (take_cnt != 2'd0 && int'(win_uops[UOP_W-1:0]) > D0_UOPS) |=> (grp_vld == 3'b001));

    // R8: a stall cycle leaves an empty group.
    a_r8_stall_empty: assert property (@(posedge clk) disable iff (!rst_n)
        grp_stall |-> (grp_vld == 3'b000));

    // R8: each reported stall advanced the stall counter by one.
    a_r8_stall_count: assert property (@(posedge clk) disable iff (!rst_n)
        grp_stall |-> (stall_cycles == $past(stall_cycles) + CNT_W'(1)));
endmodule

// File: tb/decode_steer_bench.sv
module decode_steer_bench;
    localparam int TAG_W = 6;
    localparam int UOP_W = 4;
    localparam int LEN_W = 4;
    localparam int PFX_W = 3;
    localparam int CNT_W = 16;

    typedef struct packed {
        logic [3:0] u;
        logic [3:0] l;
        logic [2:0] p;
        logic       c;
        logic       f;
    } ins_t;

    typedef struct packed {
        ins_t       a;
        ins_t       b;
        ins_t       d;
        logic [2:0] vld;
        logic [3:0] xs;
        logic [2:0] xm;
        logic [4:0] xu;
        logic [3:0] req;
    } vec_t;

    function automatic ins_t mk(int u, int l, int p, int c, int f);
        mk = '{u: 4'(u), l: 4'(l), p: 3'(p), c: 1'(c), f: 1'(f)};
    endfunction

    localparam ins_t S1 = mk(1, 3, 0, 0, 0);
    localparam int NV = 21;
    // Fields: lane0, lane1, lane2, valid, expected stalls, mask, uops, requirement.
    localparam vec_t VT [NV] = '{
        '{mk(4,3,0,0,0), S1, mk(1,2,0,0,0), 3'b111, 4'd0, 3'b111, 5'd6, 4'd9}, // R9 4-1-1
        '{mk(2,3,0,0,0), mk(2,3,0,0,0), mk(2,3,0,0,0), 3'b111, 4'd0, 3'b001, 5'd2, 4'd9}, // R9 2-2-2
        '{S1, S1, S1, 3'b111, 4'd0, 3'b111, 5'd3, 4'd2},                    // R2
        '{S1, mk(1,9,0,0,0), S1, 3'b111, 4'd0, 3'b001, 5'd1, 4'd3},         // R3 length 9
        '{S1, mk(1,8,0,0,0), S1, 3'b111, 4'd0, 3'b111, 5'd3, 4'd3},         // R3 length 8
        '{S1, mk(1,3,0,0,1), S1, 3'b111, 4'd0, 3'b001, 5'd1, 4'd4},         // R4 lane1 start
        '{S1, S1, mk(1,3,0,0,1), 3'b111, 4'd0, 3'b011, 5'd2, 4'd4},         // R4 lane2 start
        '{mk(1,3,0,0,1), S1, S1, 3'b111, 4'd0, 3'b111, 5'd3, 4'd4},         // R4 head start
        '{mk(5,3,0,0,0), S1, S1, 3'b111, 4'd1, 3'b001, 5'd5, 4'd5},         // R5 5 uops
        '{mk(9,3,0,0,0), S1, S1, 3'b111, 4'd2, 3'b001, 5'd9, 4'd5},         // R5 9 uops
        '{mk(4,3,0,0,0), mk(2,3,0,0,0), S1, 3'b111, 4'd0, 3'b001, 5'd4, 4'd3}, // R3 2-uop lane1
        '{mk(1,4,0,1,0), S1, S1, 3'b111, 4'd3, 3'b111, 5'd3, 4'd6},         // R6 head flag
        '{S1, mk(1,4,0,1,0), S1, 3'b111, 4'd0, 3'b001, 5'd1, 4'd6},         // R6 lane1 flag
        '{mk(1,4,1,0,0), S1, S1, 3'b111, 4'd0, 3'b111, 5'd3, 4'd7},         // R7 one prefix
        '{mk(1,5,2,0,0), S1, S1, 3'b111, 4'd2, 3'b111, 5'd3, 4'd7},         // R7 two prefixes
        '{mk(6,6,3,0,0), S1, S1, 3'b111, 4'd4, 3'b001, 5'd6, 4'd7},         // R7 with R5
        '{S1, mk(1,4,1,0,0), S1, 3'b111, 4'd0, 3'b111, 5'd3, 4'd7},         // R7 lane1 one prefix
        '{S1, S1, mk(0,0,0,0,0), 3'b011, 4'd0, 3'b011, 5'd2, 4'd2},         // R2 two valid
        '{S1, S1, mk(1,5,2,0,0), 3'b111, 4'd0, 3'b011, 5'd2, 4'd7},         // R7 lane2 two prefixes
        '{mk(8,3,0,0,0), S1, S1, 3'b111, 4'd1, 3'b001, 5'd8, 4'd5},         // R5 8 uops
        '{mk(13,7,0,1,0), S1, S1, 3'b111, 4'd6, 3'b001, 5'd13, 4'd5}        // R5 with R6
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [2:0]           win_vld = '0;
    logic [3*TAG_W-1:0]   win_tag = '0;
    logic [3*UOP_W-1:0]   win_uops = '0;
    logic [3*LEN_W-1:0]   win_len = '0;
    logic [3*PFX_W-1:0]   win_pfx = '0;
    logic [2:0]           win_lcp = '0;
    logic [2:0]           win_first = '0;
    logic [1:0]           take_cnt;
    logic [2:0]           grp_vld;
    logic [3*TAG_W-1:0]   grp_tag;
    logic [UOP_W:0]       grp_uops;
    logic                 grp_stall;
    logic [CNT_W-1:0]     stall_cycles;
    logic [CNT_W-1:0]     active_cycles;

    int   n_chk = 0;
    int   n_bad = 0;
    ins_t prog [8];

    always #5 clk = ~clk;

    decode_steer u_decode_steer (
        .clk(clk), .rst_n(rst_n), .win_vld(win_vld), .win_tag(win_tag),
        .win_uops(win_uops), .win_len(win_len), .win_pfx(win_pfx),
        .win_lcp(win_lcp), .win_first(win_first), .take_cnt(take_cnt),
        .grp_vld(grp_vld), .grp_tag(grp_tag), .grp_uops(grp_uops),
        .grp_stall(grp_stall), .stall_cycles(stall_cycles),
        .active_cycles(active_cycles)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put_lane(input int k, input ins_t x, input int tag);
        win_uops[k*UOP_W +: UOP_W] = x.u;
        win_len[k*LEN_W +: LEN_W]  = x.l;
        win_pfx[k*PFX_W +: PFX_W]  = x.p;
        win_lcp[k]                 = x.c;
        win_first[k]               = x.f;
        win_tag[k*TAG_W +: TAG_W]  = TAG_W'(tag);
    endtask

    task automatic run_prog(input int n, input int xcyc, input int xst, input string req);
        int a0, s0, ptr, t;
        a0 = int'(active_cycles);
        s0 = int'(stall_cycles);
        ptr = 0;
        @(negedge clk);
        for (int g = 0; g < 64 && ptr < n; g++) begin
            for (int k = 0; k < 3; k++) begin
                win_vld[k] = (ptr + k < n);
                put_lane(k, (ptr + k < n) ? prog[ptr + k] : '0, ptr + k);
            end
            #4 t = int'(take_cnt);
            @(negedge clk);
            ptr += t;
        end
        win_vld = '0;
        @(negedge clk);
        chk(int'(active_cycles) - a0 == xcyc, req, "stream decode cycles", int'(active_cycles) - a0, xcyc);
        chk(int'(stall_cycles) - s0 == xst, req, "stream stall cycles", int'(stall_cycles) - s0, xst);
    endtask

    initial begin : watchdog
        #2000000;
        n_bad++;
        $display("FAIL R10 watchdog expired: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int st, t, sum_s, sum_a, exp_cnt;
        bit done;
        // R1: reset state.
        repeat (2) @(negedge clk);
        chk(grp_vld == 3'b000, "R1", "reset group", int'(grp_vld), 0);
        chk(grp_stall == 1'b0, "R1", "reset stall flag", int'(grp_stall), 0);
        chk(stall_cycles == '0 && active_cycles == '0, "R1", "reset counters",
            int'(stall_cycles) + int'(active_cycles), 0);
        chk(take_cnt == 2'd0, "R1", "reset take", int'(take_cnt), 0);
        rst_n = 1'b1;

        // Vector table walk.
        sum_s = 0;
        sum_a = 0;
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            win_vld = VT[v].vld;
            put_lane(0, VT[v].a, v * 3);
            put_lane(1, VT[v].b, v * 3 + 1);
            put_lane(2, VT[v].d, v * 3 + 2);
            st = 0;
            t = 0;
            done = 1'b0;
            for (int c = 0; c < 40 && !done; c++) begin
                #4 t = int'(take_cnt);
                @(negedge clk);
                if (t == 0) begin
                    chk(grp_stall && grp_vld == 3'b000, $sformatf("R8 (vec %0d)", v),
                        "stall cycle output", int'({grp_stall, grp_vld}), 8);
                    st++;
                end else done = 1'b1;
            end
            exp_cnt = $countones(VT[v].xm);
            chk(st == int'(VT[v].xs), $sformatf("R%0d (vec %0d)", VT[v].req, v),
                "stall cycles before issue", st, int'(VT[v].xs));
            chk(t == exp_cnt, $sformatf("R%0d (vec %0d)", VT[v].req, v), "take count", t, exp_cnt);
            chk(grp_vld == VT[v].xm, $sformatf("R%0d (vec %0d)", VT[v].req, v),
                "group mask", int'(grp_vld), int'(VT[v].xm));
            chk(int'(grp_uops) == int'(VT[v].xu), $sformatf("R9 (vec %0d)", v),
                "group uops", int'(grp_uops), int'(VT[v].xu));
            for (int k = 0; k < 3; k++)
                if (VT[v].xm[k])
                    chk(int'(grp_tag[k*TAG_W +: TAG_W]) == (v * 3 + k) % 64,
                        $sformatf("R2 (vec %0d)", v), "slot tag",
                        int'(grp_tag[k*TAG_W +: TAG_W]), (v * 3 + k) % 64);
            sum_s += int'(VT[v].xs);
            sum_a += int'(VT[v].xs) + 1;
            win_vld = '0;
        end
        @(negedge clk);
        chk(int'(stall_cycles) == sum_s, "R8", "total stall counter", int'(stall_cycles), sum_s);
        chk(int'(active_cycles) == sum_a, "R10", "total active counter", int'(active_cycles), sum_a);

        // R3/R10: 2,2,1,1,1 stream decodes in 3 cycles.
        prog[0] = mk(2,3,0,0,0); prog[1] = mk(2,3,0,0,0);
        prog[2] = S1; prog[3] = S1; prog[4] = S1;
        run_prog(5, 3, 0, "R3");
        // R4/R10: 4-1-1 twice with a window start on the third instruction.
        prog[0] = mk(4,3,0,0,0); prog[1] = S1; prog[2] = mk(1,3,0,0,1);
        prog[3] = mk(4,3,0,0,0); prog[4] = S1; prog[5] = S1;
        run_prog(6, 3, 0, "R4");
        // R5/R10: a 5-uop instruction mid-stream.
        prog[0] = S1; prog[1] = mk(5,3,0,0,0); prog[2] = S1; prog[3] = S1;
        run_prog(4, 4, 1, "R5");

        // R1: reset in the middle of a hold.
        @(negedge clk);
        win_vld = 3'b001;
        put_lane(0, mk(9,3,0,0,0), 40);
        @(negedge clk);
        rst_n = 1'b0;
        win_vld = '0;
        @(negedge clk);
        chk(grp_stall == 1'b0 && grp_vld == 3'b000, "R1", "mid-hold reset outputs",
            int'({grp_stall, grp_vld}), 0);
        chk(stall_cycles == '0 && active_cycles == '0, "R1", "mid-hold reset counters",
            int'(stall_cycles) + int'(active_cycles), 0);
        rst_n = 1'b1;
        @(negedge clk);
        win_vld = 3'b001;
        put_lane(0, S1, 41);
        #4 t = int'(take_cnt);
        chk(t == 1, "R1", "no leftover hold after reset", t, 1);
        @(negedge clk);
        chk(grp_vld == 3'b001, "R1", "group after reset", int'(grp_vld), 1);
        win_vld = '0;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule